// File: doc/BRIEF.md
# Speech excitation noise source

This block supplies the excitation bit for a frame-based speech synthesizer. On every sample step that the chip's clocking system lets through, a 17-bit linear feedback shift register advances once. When the current frame's 7-bit pitch field is zero, the frame is unvoiced and the register's top bit becomes the excitation bit. For any other pitch value the excitation bit is held at zero and a voiced request is raised, so that a separate pulse generator can take over. The register keeps advancing in both cases.

How the register is cleared depends on a build parameter. In the serial mode, which is the default, reset does not wipe the register at once. Each enabled step taken while reset is low shifts a zero into the bottom bit. The clocking system stops the enable while reset is low, so a reset held in that condition leaves the old contents in place, and the noise that follows depends on history. In the asynchronous mode, reset zeroes the register immediately, and every run that starts from reset produces the same bit stream.

Top module: `exc_noise_src`

## Requirements
- R1: The register advances only on a clock edge where `clk_en` and `step` are both 1. On every other edge its contents are unchanged.
- R2: On each advance the register shifts one place toward its top bit (bit 16). The new bit 0 is the inverted XOR of bits 16 and 13 taken before the shift. Starting from the all-zero state, the stream is therefore fixed.
- R3: While `pitch` is 0, `exc_bit` equals bit 16 of the register and `voiced_req` is 0.
- R4: While `pitch` is nonzero, `exc_bit` is 0 and `voiced_req` is 1, and the register keeps advancing under R1.
- R5: With ASYNC_CLR=0, an advance taken while `rst_n` is 0 shifts a 0 into bit 0 in place of the feedback bit. Seventeen such advances leave the register all zero.
- R6: With ASYNC_CLR=0, a reset held while no advance happens leaves the register contents unchanged.
- R7: With ASYNC_CLR=1, the register is zero as soon as `rst_n` falls and stays zero while `rst_n` is 0, whatever `clk_en` does.
- R8: With ASYNC_CLR=1, two runs that each start from a reset give identical bit streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset; its clearing effect depends on ASYNC_CLR |
| clk_en | input | 1 | Enable from the clocking system; held low while the clocks are stopped |
| step | input | 1 | Sample-step pulse |
| pitch | input | 7 | Pitch field of the current frame; 0 selects noise |
| exc_bit | output | 1 | Excitation bit for the current sample |
| voiced_req | output | 1 | High when the frame is voiced |

## Verification
Both outputs are combinational from the register. An advance is therefore visible in the same cycle as the edge that takes it, and an asynchronous clear shows as soon as `rst_n` falls. The bench drives inputs on the falling edge. It compares the outputs of a serial-clear instance and an asynchronous-clear instance with its own register models one time unit after each rising edge, that is, right after the register has settled. For the reset scenarios, the bench checks the bits that follow release against the models, which shows whether the old contents survived (R6), were partly shifted out (R5), or were wiped (R7, R8).

// File: rtl/exc_noise_pkg.sv
// Shared defaults and the feedback helper for the excitation noise source.
package exc_noise_pkg;
    localparam int LFSR_W_DEF  = 17;
    localparam int TAP_A_DEF   = 17;
    localparam int TAP_B_DEF   = 14;
    localparam int PITCH_W_DEF = 7;

    // Inverted XOR of two tap bits; makes the all-zero state a legal state.
    function automatic logic xnor_tap(input logic a, input logic b);
        return ~(a ^ b);
    endfunction
endpackage

// File: rtl/exc_lfsr_core.sv
// Fibonacci shift register for the noise source.
// Assumes: adv is already qualified by the clock enable.
// ASYNC_CLR=0: reset only shifts zeros in on advances.
// ASYNC_CLR=1: reset clears all bits at once.
module exc_lfsr_core
    import exc_noise_pkg::*;
#(
    parameter int W         = LFSR_W_DEF,
    parameter int TAP_A     = TAP_A_DEF,
    parameter int TAP_B     = TAP_B_DEF,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic msb
);
    localparam int TOP = W - 1;
    localparam int IA  = TAP_A - 1;
    localparam int IB  = TAP_B - 1;

    logic [W-1:0] q;
    logic         fb;

    // Feedback bit from the two taps.
    always_comb fb = xnor_tap(q[IA], q[IB]);

    generate
        if (ASYNC_CLR) begin : g_async
            // Immediate clear on reset; shift on advance otherwise.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   q <= '0;
                else if (adv) q <= {q[W-2:0], fb};
            end

            // R7: register is zero at every edge seen while reset is low
            always @(posedge clk) begin
                if (!rst_n) a_r7_cleared: assert (q == '0);
            end

            a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
                !adv |=> $stable(q));

            a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
                adv |=> (q[W-1:1] == $past(q[W-2:0])));
        end else begin : g_serial
            logic armed = 1'b0;

            // Marks that one edge has passed so $past has history.
            always_ff @(posedge clk) armed <= 1'b1;

            // Shift on advance; reset substitutes a zero for the feedback bit.
            always_ff @(posedge clk) begin
                if (adv) q <= {q[W-2:0], (rst_n ? fb : 1'b0)};
            end

            a_r1_hold: assert property (@(posedge clk) disable iff (!armed)
                !adv |=> $stable(q));

            a_r2_shift: assert property (@(posedge clk) disable iff (!armed)
                adv |=> (q[W-1:1] == $past(q[W-2:0])));

            a_r5_zero_in: assert property (@(posedge clk) disable iff (!armed)
                (!rst_n && adv) |=> (q[0] == 1'b0));

            a_r6_kept: assert property (@(posedge clk) disable iff (!armed)
                (!rst_n && !adv) |=> $stable(q));
        end
    endgenerate

    // Noise bit taken from the top stage.
    assign msb = q[TOP];
endmodule

// File: rtl/exc_pitch_decode.sv
// Chooses between noise and voiced excitation from the frame's pitch field.
// Assumes: pitch is stable for the whole frame; a zero value means unvoiced.
module exc_pitch_decode
    import exc_noise_pkg::*;
#(
    parameter int PITCH_W = PITCH_W_DEF
) (
    input  logic [PITCH_W-1:0] pitch,
    input  logic               noise_bit,
    output logic               exc_bit,
    output logic               voiced_req
);
    logic unvoiced;

    // Zero pitch selects noise excitation.
    always_comb unvoiced = (pitch == '0);

    // Output mux: noise for unvoiced frames, request for voiced frames.
    always_comb begin
        exc_bit    = unvoiced ? noise_bit : 1'b0;
        voiced_req = ~unvoiced;
    end
endmodule

// File: rtl/exc_noise_src.sv
// Top of the excitation noise source. It gates the sample step with the
// clocking-system enable, runs the shift register and decodes the pitch.
// Assumes: clk_en is held low while the clocks are stopped, including during
// reset on the real clocking system.
module exc_noise_src
    import exc_noise_pkg::*;
#(
    parameter int LFSR_W    = LFSR_W_DEF,
    parameter int TAP_A     = TAP_A_DEF,
    parameter int TAP_B     = TAP_B_DEF,
    parameter int PITCH_W   = PITCH_W_DEF,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clk_en,
    input  logic               step,
    input  logic [PITCH_W-1:0] pitch,
    output logic               exc_bit,
    output logic               voiced_req
);
    logic adv;
    logic noise_bit;

    // An advance needs both the clocking enable and a sample step.
    assign adv = clk_en & step;

    exc_lfsr_core #(
        .W(LFSR_W), .TAP_A(TAP_A), .TAP_B(TAP_B), .ASYNC_CLR(ASYNC_CLR)
    ) u_lfsr (
        .clk(clk), .rst_n(rst_n), .adv(adv), .msb(noise_bit)
    );

    exc_pitch_decode #(.PITCH_W(PITCH_W)) u_dec (
        .pitch(pitch), .noise_bit(noise_bit),
        .exc_bit(exc_bit), .voiced_req(voiced_req)
    );

    a_r3_noise_out: assert property (@(posedge clk) disable iff (!rst_n)
        (pitch == '0) |-> (exc_bit == noise_bit && !voiced_req));

    a_r4_voiced_out: assert property (@(posedge clk) disable iff (!rst_n)
        (pitch != '0) |-> (!exc_bit && voiced_req));
endmodule

// File: tb/exc_noise_src_tb.sv
// Directed bench: a serial-clear and an asynchronous-clear instance share the
// same stimulus. Each is checked against its own model of the register.
module exc_noise_src_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_LEN    = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b0;
    logic       step = 1'b0;
    logic [6:0] pitch = '0;
    logic       exc_s, voiced_s, exc_a, voiced_a;

    logic [16:0] ms = '0;   // model, serial clear
    logic [16:0] ma = '0;   // model, asynchronous clear
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    exc_noise_src #(.ASYNC_CLR(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .step(step), .pitch(pitch),
        .exc_bit(exc_s), .voiced_req(voiced_s)
    );

    exc_noise_src #(.ASYNC_CLR(1'b1)) dut_async_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .step(step), .pitch(pitch),
        .exc_bit(exc_a), .voiced_req(voiced_a)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [16:0] model_adv(input logic [16:0] s, input logic zero_in);
        return {s[15:0], (zero_in ? 1'b0 : ~(s[16] ^ s[13]))};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, update the models at the rising
    // edge, and compare both instances one time unit later.
    task automatic tick(input logic r, input logic en, input logic st,
                        input logic [6:0] p, input bit chk, input string tag);
        logic [1:0] exp_s, exp_a;
        @(negedge clk);
        rst_n = r; clk_en = en; step = st; pitch = p;
        @(posedge clk);
        if (en && st) ms = model_adv(ms, !r);
        if (!r) ma = '0;
        else if (en && st) ma = model_adv(ma, 1'b0);
        #1;
        if (chk) begin
            exp_s = {((p == 7'd0) ? ms[16] : 1'b0), (p != 7'd0)};
            exp_a = {((p == 7'd0) ? ma[16] : 1'b0), (p != 7'd0)};
            check({exc_s, voiced_s} == exp_s, tag, "serial {exc,voiced}",
                  int'({exc_s, voiced_s}), int'(exp_s));
            check({exc_a, voiced_a} == exp_a, tag, "async {exc,voiced}",
                  int'({exc_a, voiced_a}), int'(exp_a));
        end
    endtask

    // R5/R7: power-up reset with advances flushes both registers to zero.
    task automatic t_reset_state();
        for (int i = 0; i < 20; i++) tick(1'b0, 1'b1, 1'b1, 7'd0, (i >= 17), "R5");
        check(ms == '0, "R5", "serial model flushed", int'(ms), 0);
    endtask

    // R2/R3: free-running noise from the zero state.
    task automatic t_noise_run();
        for (int i = 0; i < 60; i++) tick(1'b1, 1'b1, 1'b1, 7'd0, 1'b1, "R2_R3");
    endtask

    // R1: no advance without both enable and step.
    task automatic t_gating();
        for (int i = 0; i < 6; i++) tick(1'b1, 1'b0, 1'b1, 7'd0, 1'b1, "R1");
        for (int i = 0; i < 6; i++) tick(1'b1, 1'b1, 1'b0, 7'd0, 1'b1, "R1");
        for (int i = 0; i < 30; i++) tick(1'b1, 1'b1, 1'b1, 7'd0, 1'b1, "R1");
    endtask

    // R4: voiced frame masks noise while the register keeps running.
    task automatic t_voiced();
        for (int i = 0; i < 12; i++) tick(1'b1, 1'b1, 1'b1, 7'd5, 1'b1, "R4");
        for (int i = 0; i < 4; i++) tick(1'b1, 1'b1, 1'b1, 7'h7f, 1'b1, "R4");
        for (int i = 0; i < 30; i++) tick(1'b1, 1'b1, 1'b1, 7'd0, 1'b1, "R4");
    endtask

    // R6/R7: reset with the clocks stopped keeps the serial register, wipes async.
    task automatic t_reset_clk_stopped();
        check(ms != '0, "R6", "serial model nonzero before reset", int'(ms), 1);
        for (int i = 0; i < 30; i++) tick(1'b0, 1'b0, 1'b1, 7'd0, 1'b1, "R6_R7");
        for (int i = 0; i < 60; i++) tick(1'b1, 1'b1, 1'b1, 7'd0, 1'b1, "R6_R7");
    endtask

    // R5: a short enabled reset only shifts a few zeros in.
    task automatic t_partial_clear();
        for (int i = 0; i < 5; i++) tick(1'b0, 1'b1, 1'b1, 7'd0, 1'b1, "R5");
        for (int i = 0; i < 40; i++) tick(1'b1, 1'b1, 1'b1, 7'd0, 1'b1, "R5");
    endtask

    // R8: two runs from reset give the same asynchronous-mode stream.
    task automatic t_repeat();
        logic [RUN_LEN-1:0] run_bits [2];
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < 8; i++) tick(1'b0, 1'b0, 1'b0, 7'd0, 1'b1, "R8");
            for (int i = 0; i < RUN_LEN; i++) begin
                tick(1'b1, 1'b1, 1'b1, 7'd0, 1'b1, "R8");
                run_bits[r][i] = exc_a;
            end
        end
        check(run_bits[0] == run_bits[1], "R8", "run streams equal (low 32 bits)",
              int'(run_bits[0][31:0]), int'(run_bits[1][31:0]));
    endtask

    initial begin
        t_reset_state();
        t_noise_run();
        t_gating();
        t_voiced();
        t_reset_clk_stopped();
        t_partial_clear();
        t_repeat();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule